// File: doc/BRIEF.md
# Grouped Priority Interrupt Arbiter

This block looks at a set of external interrupt lines and picks the one to be served next. A line takes part only when it is pending, enabled and not already being serviced. Each line carries a 3-bit priority in which the value 0 is the most urgent. Among the lines taking part, the most urgent value wins. When several lines share that value, the line with the lowest number wins.

A grouping control splits each priority value into an upper group part and a lower subpriority part. The split affects only preemption. The block raises a preempt request when the winner's group part is strictly more urgent than the group part of the handler now running. It also raises the request whenever no handler is running.

The winning ID, the valid flag and the preempt request are registered. They therefore show the inputs as they stood one clock edge earlier.

Top module: `irq_grp_arbiter`

## Requirements
- R1: While reset is held, and on the first edge after it, win_valid_o, preempt_o and win_id_o are all 0.
- R2: A line is eligible only when its pend_i, en_i and, inverted, its act_i bit are all 1. With no eligible line, win_valid_o=0, win_id_o=0 and preempt_o=0.
- R3: The winner is the eligible line with the numerically smallest priority field. The priority of line k occupies prio_i[3k+2:3k], and 0 is the most urgent value.
- R4: Among eligible lines with equal priority values, the lowest line number wins.
- R5: With grouping value g (grp_i, 0..3), the group part is priority>>g and the subpriority is the low g bits. The selection order among simultaneous lines, group first and then subpriority, is the same for every g.
- R6: preempt_o=1 only if win_valid_o=1 and either no handler is running or (winner priority>>g) < (handler_prio_i>>g). Equal group parts do not preempt.
- R7: When handler_act_i=0 and a winner exists, preempt_o=1.
- R8: With grp_i=3, every line is in one group, so preempt_o=0 whenever handler_act_i=1.
- R9: The outputs change on the first rising edge after the inputs change, and not before.
- R10: 53 lines are supported, and every line number from 0 to 52, including 52, can be reported as the winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | 53 | Per-line pending status |
| en_i | input | 53 | Per-line enable |
| act_i | input | 53 | Per-line already-active status |
| prio_i | input | 159 | Packed 3-bit priorities, line k at bits [3k+2:3k] |
| grp_i | input | 2 | Grouping value: number of subpriority bits |
| handler_act_i | input | 1 | A handler is currently running |
| handler_prio_i | input | 3 | Priority of the running handler |
| win_id_o | output | 6 | Registered winning line number |
| win_valid_o | output | 1 | Registered: a winner exists |
| preempt_o | output | 1 | Registered preempt request |

## Verification
The assertions assume that every input is a defined 0 or 1 at each rising edge, and that grp_i stays within 0..3. The bench drives all inputs on falling edges with defined values, and it uses only grouping values 0 to 3. Priorities of the lines that are not under test are parked at 7, the least urgent value, so that the lines under test decide the outcome.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   // Returns a grouping value that is never larger than the priority width.
   function automatic int unsigned clamp_grp(int unsigned g, int unsigned prio_w);
      return (g > prio_w) ? prio_w : g;
   endfunction

endpackage

// File: rtl/irq_elig_mask.sv
module irq_elig_mask #(
   parameter int NUM_LINES = 53
) (
   input  logic [NUM_LINES-1:0] pend_i,
   input  logic [NUM_LINES-1:0] en_i,
   input  logic [NUM_LINES-1:0] act_i,
   output logic [NUM_LINES-1:0] elig_o
);

   for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
      assign elig_o[k] = pend_i[k] & en_i[k] & ~act_i[k];
   end

endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree #(
   parameter int NUM_LINES = 53,
   parameter int PRIO_W    = 3
) (
   input  logic [NUM_LINES-1:0]        elig_i,
   input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
   output logic                        any_o,
   output logic [$clog2(NUM_LINES)-1:0] id_o,
   output logic [PRIO_W-1:0]           prio_o
);

   localparam int LVLS   = $clog2(NUM_LINES);
   localparam int ID_W   = LVLS;
   localparam int LEAVES = 1 << LVLS;

   for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
      localparam int CNT = LEAVES >> l;
      logic              v  [CNT];
      logic [PRIO_W-1:0] p  [CNT];
      logic [ID_W-1:0]   id [CNT];

      for (genvar k = 0; k < CNT; k++) begin : g_node
         if (l == 0) begin : g_leaf
            if (k < NUM_LINES) begin : g_real
               assign v[k]  = elig_i[k];
               assign p[k]  = prio_i[k*PRIO_W +: PRIO_W];
               assign id[k] = ID_W'(k);
            end else begin : g_pad
               assign v[k]  = 1'b0;
               assign p[k]  = '1;
               assign id[k] = '0;
            end
         end else begin : g_cmp
            logic take_l;
            // Left child always holds the lower line numbers, so ties go left.
            assign take_l = g_lvl[l-1].v[2*k] &&
                            (!g_lvl[l-1].v[2*k+1] ||
                             (g_lvl[l-1].p[2*k] <= g_lvl[l-1].p[2*k+1]));
            assign v[k]  = g_lvl[l-1].v[2*k] | g_lvl[l-1].v[2*k+1];
            assign p[k]  = take_l ? g_lvl[l-1].p[2*k]  : g_lvl[l-1].p[2*k+1];
            assign id[k] = take_l ? g_lvl[l-1].id[2*k] : g_lvl[l-1].id[2*k+1];
         end
      end
   end

   assign any_o  = g_lvl[LVLS].v[0];
   assign id_o   = g_lvl[LVLS].id[0];
   assign prio_o = g_lvl[LVLS].p[0];

endmodule

// File: rtl/irq_group_cmp.sv
module irq_group_cmp #(
   parameter int PRIO_W = 3
) (
   input  logic                        valid_i,
   input  logic [PRIO_W-1:0]           win_prio_i,
   input  logic                        cur_act_i,
   input  logic [PRIO_W-1:0]           cur_prio_i,
   input  logic [$clog2(PRIO_W+1)-1:0] grp_i,
   output logic                        preempt_o
);

   logic [PRIO_W-1:0] win_grp;
   logic [PRIO_W-1:0] cur_grp;

   always_comb begin
      win_grp   = win_prio_i >> grp_i;
      cur_grp   = cur_prio_i >> grp_i;
      preempt_o = valid_i && (!cur_act_i || (win_grp < cur_grp));
   end

endmodule

// File: rtl/irq_grp_arbiter.sv
module irq_grp_arbiter #(
   parameter int NUM_LINES = 53,
   parameter int PRIO_W    = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_LINES-1:0]          pend_i,
   input  logic [NUM_LINES-1:0]          en_i,
   input  logic [NUM_LINES-1:0]          act_i,
   input  logic [NUM_LINES*PRIO_W-1:0]   prio_i,
   input  logic [$clog2(PRIO_W+1)-1:0]   grp_i,
   input  logic                          handler_act_i,
   input  logic [PRIO_W-1:0]             handler_prio_i,
   output logic [$clog2(NUM_LINES)-1:0]  win_id_o,
   output logic                          win_valid_o,
   output logic                          preempt_o
);

   import irq_arb_pkg::*;

   localparam int ID_W  = $clog2(NUM_LINES);
   localparam int GRP_W = $clog2(PRIO_W+1);

   if (NUM_LINES < 2) begin : g_bad_lines
      $error("NUM_LINES must be at least 2");
   end
   if ((PRIO_W < 1) || (PRIO_W > 8)) begin : g_bad_prio
      $error("PRIO_W must be between 1 and 8");
   end

   logic [NUM_LINES-1:0] elig_w;
   logic                 any_w;
   logic [ID_W-1:0]      id_w;
   logic [PRIO_W-1:0]    prio_w;
   logic [GRP_W-1:0]     grp_eff;
   logic                 pre_w;

   assign grp_eff = GRP_W'(clamp_grp(int'(grp_i), PRIO_W));

   irq_elig_mask #(.NUM_LINES(NUM_LINES)) i_mask (
      .pend_i (pend_i),
      .en_i   (en_i),
      .act_i  (act_i),
      .elig_o (elig_w)
   );

   irq_prio_tree #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) i_tree (
      .elig_i (elig_w),
      .prio_i (prio_i),
      .any_o  (any_w),
      .id_o   (id_w),
      .prio_o (prio_w)
   );

   irq_group_cmp #(.PRIO_W(PRIO_W)) i_gcmp (
      .valid_i    (any_w),
      .win_prio_i (prio_w),
      .cur_act_i  (handler_act_i),
      .cur_prio_i (handler_prio_i),
      .grp_i      (grp_eff),
      .preempt_o  (pre_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_id_o    <= '0;
         win_valid_o <= 1'b0;
         preempt_o   <= 1'b0;
      end else begin
         win_id_o    <= any_w ? id_w : '0;
         win_valid_o <= any_w;
         preempt_o   <= pre_w;
      end
   end

   // R2: no eligible line in the previous cycle gives no winner and no request
   assert_idle_no_winner_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|$past(elig_w))) |-> (!win_valid_o && !preempt_o && (win_id_o == '0)));

   // R2: a reported winner was eligible in the previous cycle
   assert_winner_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid_o |-> (|(($past(elig_w) >> win_id_o) & NUM_LINES'(1))));

   // R6: a preempt request always comes with a valid winner
   assert_preempt_has_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
      preempt_o |-> win_valid_o);

   // R7: with no running handler, any winner requests preemption
   assert_idle_handler_preempts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid_o && !$past(handler_act_i)) |-> preempt_o);

   // R8: one single group never preempts a running handler
   assert_single_group_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(handler_act_i) && (int'($past(grp_i)) >= PRIO_W)) |-> !preempt_o);

endmodule

// File: tb/test_irq_grp_arbiter.sv
`timescale 1ns/1ps
module test_irq_grp_arbiter;

   localparam int N = 53;
   localparam int NV = 11;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [N-1:0]  pend, en, act;
   logic [2:0]    pr [N];
   logic [N*3-1:0] prio_flat;
   logic [1:0]    grp;
   logic          h_act;
   logic [2:0]    h_prio;
   logic [5:0]    win_id;
   logic          win_valid, preempt;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   always_comb begin
      for (int k = 0; k < N; k++) prio_flat[k*3 +: 3] = pr[k];
   end

   irq_grp_arbiter i_irq_grp_arbiter (
      .clk            (clk),
      .rst_n          (rst_n),
      .pend_i         (pend),
      .en_i           (en),
      .act_i          (act),
      .prio_i         (prio_flat),
      .grp_i          (grp),
      .handler_act_i  (h_act),
      .handler_prio_i (h_prio),
      .win_id_o       (win_id),
      .win_valid_o    (win_valid),
      .preempt_o      (preempt)
   );

   // Vector: id_a, pr_a, id_b, pr_b, grp, handler_act, handler_prio, exp_id, exp_valid, exp_pre
   localparam logic [31:0] VEC [NV] = '{
      {6'd5,  3'd3, 6'd9,  3'd1, 2'd0, 1'b0, 3'd0, 6'd9,  1'b1, 1'b1}, // R3 R7
      {6'd5,  3'd2, 6'd9,  3'd2, 2'd0, 1'b0, 3'd0, 6'd5,  1'b1, 1'b1}, // R4
      {6'd52, 3'd0, 6'd40, 3'd0, 2'd0, 1'b1, 3'd1, 6'd40, 1'b1, 1'b1}, // R4 R6
      {6'd10, 3'd4, 6'd11, 3'd5, 2'd1, 1'b1, 3'd5, 6'd10, 1'b1, 1'b0}, // R6 equal group
      {6'd10, 3'd4, 6'd11, 3'd5, 2'd0, 1'b1, 3'd5, 6'd10, 1'b1, 1'b1}, // R6
      {6'd3,  3'd1, 6'd7,  3'd0, 2'd3, 1'b1, 3'd7, 6'd7,  1'b1, 1'b0}, // R8
      {6'd3,  3'd1, 6'd7,  3'd0, 2'd3, 1'b0, 3'd0, 6'd7,  1'b1, 1'b1}, // R7
      {6'd20, 3'd6, 6'd21, 3'd3, 2'd2, 1'b1, 3'd4, 6'd21, 1'b1, 1'b1}, // R5 R6
      {6'd20, 3'd6, 6'd21, 3'd3, 2'd2, 1'b1, 3'd2, 6'd21, 1'b1, 1'b0}, // R5
      {6'd52, 3'd0, 6'd52, 3'd0, 2'd0, 1'b0, 3'd0, 6'd52, 1'b1, 1'b1}, // R10
      {6'd0,  3'd7, 6'd1,  3'd7, 2'd1, 1'b1, 3'd7, 6'd0,  1'b1, 1'b0}  // R4 R6
   };

   task automatic chk(input string req, input int actual, input int expected);
      n_checks++;
      if (actual != expected) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
      end
   endtask

   task automatic clear_lines();
      pend = '0; en = '0; act = '0;
      for (int k = 0; k < N; k++) pr[k] = 3'd7;
      grp = 2'd0; h_act = 1'b0; h_prio = 3'd0;
   endtask

   task automatic settle();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      clear_lines();
      rst_n = 1'b0;
      // R1: eligible input during reset must not show up
      pend[3] = 1'b1; en[3] = 1'b1; pr[3] = 3'd0;
      repeat (3) @(negedge clk);
      chk("R1 valid", int'(win_valid), 0);
      chk("R1 preempt", int'(preempt), 0);
      chk("R1 id", int'(win_id), 0);
      rst_n = 1'b1;
      clear_lines();
      settle();

      // Table walk
      for (int v = 0; v < NV; v++) begin
         clear_lines();
         pend[VEC[v][31:26]] = 1'b1; en[VEC[v][31:26]] = 1'b1; pr[VEC[v][31:26]] = VEC[v][25:23];
         pend[VEC[v][22:17]] = 1'b1; en[VEC[v][22:17]] = 1'b1; pr[VEC[v][22:17]] = VEC[v][16:14];
         grp = VEC[v][13:12]; h_act = VEC[v][11]; h_prio = VEC[v][10:8];
         settle();
         chk($sformatf("R3 R4 R10 table id vec %0d", v), int'(win_id), int'(VEC[v][7:2]));
         chk($sformatf("R2 table valid vec %0d", v), int'(win_valid), int'(VEC[v][1]));
         chk($sformatf("R5 R6 R7 R8 table preempt vec %0d", v), int'(preempt), int'(VEC[v][0]));
      end

      // R2: disabled line ignored
      clear_lines();
      pend[4] = 1'b1; pr[4] = 3'd0;
      pend[8] = 1'b1; en[8] = 1'b1; pr[8] = 3'd5;
      settle();
      chk("R2 disabled ignored", int'(win_id), 8);
      // R2: active line ignored
      en[4] = 1'b1; act[4] = 1'b1;
      settle();
      chk("R2 active ignored", int'(win_id), 8);
      act[4] = 1'b0;
      settle();
      chk("R2 line now eligible", int'(win_id), 4);

      // R9: one-edge latency
      pend[4] = 1'b0;
      #1;
      chk("R9 no change before edge", int'(win_id), 4);
      settle();
      chk("R9 change after edge", int'(win_id), 8);

      // R2: nothing eligible
      pend = '0;
      settle();
      chk("R2 none valid", int'(win_valid), 0);
      chk("R2 none id", int'(win_id), 0);
      chk("R2 none preempt", int'(preempt), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule